// File: doc/BRIEF.md
# RS-485 Transceiver Control Core

This block is the digital decision logic of an isolated RS-485 transceiver that can be wired for half-duplex or full-duplex use. On the transmit side it combines the driver enable, the data bit, both supply-good flags and an internal over-temperature latch. From these it decides whether the differential pair is driven and at which polarity.

On the receive side it turns a signed differential-voltage code in millivolts into a receive bit. The receive threshold sits below zero and has hysteresis, so an idle, open or shorted bus always reads as logic high. A receiver enable, active low, either passes that bit out or reports the output as released. The analog front end supplies the millivolt code, an open-inputs flag and a die-temperature code. The block sits between that front end and the pin logic.

Top module: `rs485_ctl`

## Requirements
- R1: With `drv_en` high, both supplies good and `therm_trip` low, `drv_on` is 1, `y_out` equals `tx_bit` and `z_out` is its inverse, in the same cycle.
- R2: Whenever `drv_on` is 0 the pair is released: `y_out` and `z_out` both read 0. `drv_en` low always forces `drv_on` to 0.
- R3: The receive bit is registered on the rising clock edge. A code above −30 mV gives 1 and a code below −200 mV gives 0, both visible on `rx_out` after the next edge.
- R4: When `lines_open` is 1, the receive bit becomes 1 at the next edge whatever the code.
- R5: Hysteresis around a −100 mV switching point. The bit goes to 0 when the code is below −107 mV and to 1 when it is above −93 mV. From −107 to −93 mV inclusive it keeps its previous value.
- R6: With `rx_en_n` high, `rx_hiz` is 1 and `rx_out` reads 1.
- R7: `therm_trip` sets at the edge where the sampled temperature is at least 150 °C. It clears at the edge where the temperature is at most 140 °C, and holds in between. While it is set, `drv_on` is 0.
- R8: With `bus_pwr_ok` low, `drv_on` is 0. With the receiver enabled, `rx_out` reads 1.
- R9: With `logic_pwr_ok` low, `drv_on` is 0 and `rx_hiz` is 1.
- R10: After reset, `therm_trip` is 0 and the receive bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_en | input | 1 | Driver enable, active high |
| rx_en_n | input | 1 | Receiver enable, active low |
| tx_bit | input | 1 | Data bit to transmit |
| diff_mv | input | DIFF_W | Signed differential input voltage A−B in mV |
| lines_open | input | 1 | Receiver inputs detected open |
| die_temp | input | TEMP_W | Signed die temperature in °C |
| logic_pwr_ok | input | 1 | Logic-side supply good |
| bus_pwr_ok | input | 1 | Bus-side supply good |
| drv_on | output | 1 | Driver actively drives the pair |
| y_out | output | 1 | Non-inverting driver level (0 when released) |
| z_out | output | 1 | Inverting driver level (0 when released) |
| rx_out | output | 1 | Receive data level |
| rx_hiz | output | 1 | Receive output released |
| therm_trip | output | 1 | Thermal shutdown active |

## Verification
The assertions assume that the millivolt code and the temperature code are settled before each rising edge. They also assume that the supply flags and enables are ordinary synchronous levels with no sub-cycle glitches. The bench changes every input only on the falling edge, so each registered decision sees one stable value. It samples a little after the rising edge for registered results and a little after the change for combinational ones. The threshold and hysteresis codes it uses stay inside the signed input width.

// File: rtl/rs485_ctl.sv
module rs485_ctl #(
  parameter int DIFF_W  = 16,
  parameter int TEMP_W  = 10,
  parameter int SW_MV   = -100,
  parameter int HYST_MV = 7,
  parameter int HOT_C   = 150,
  parameter int COOL_C  = 140
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     drv_en,
  input  logic                     rx_en_n,
  input  logic                     tx_bit,
  input  logic signed [DIFF_W-1:0] diff_mv,
  input  logic                     lines_open,
  input  logic signed [TEMP_W-1:0] die_temp,
  input  logic                     logic_pwr_ok,
  input  logic                     bus_pwr_ok,
  output logic                     drv_on,
  output logic                     y_out,
  output logic                     z_out,
  output logic                     rx_out,
  output logic                     rx_hiz,
  output logic                     therm_trip
);
  localparam logic signed [DIFF_W-1:0] LO_PT = DIFF_W'(SW_MV - HYST_MV);
  localparam logic signed [DIFF_W-1:0] HI_PT = DIFF_W'(SW_MV + HYST_MV);
  localparam logic signed [TEMP_W-1:0] HOT_T = TEMP_W'(HOT_C);
  localparam logic signed [TEMP_W-1:0] COOL_T = TEMP_W'(COOL_C);

  logic rx_lvl;
  logic go_low, go_high;

  assign go_low  = !lines_open && (diff_mv < LO_PT);
  assign go_high = lines_open || (diff_mv > HI_PT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_lvl <= 1'b1;
    else if (go_high) rx_lvl <= 1'b1;
    else if (go_low)  rx_lvl <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  therm_trip <= 1'b0;
    else if (die_temp >= HOT_T)  therm_trip <= 1'b1;
    else if (die_temp <= COOL_T) therm_trip <= 1'b0;
  end

  assign drv_on = drv_en && bus_pwr_ok && logic_pwr_ok && !therm_trip;
  assign y_out  = drv_on && tx_bit;
  assign z_out  = drv_on && !tx_bit;
  assign rx_hiz = rx_en_n || !logic_pwr_ok;
  assign rx_out = rx_hiz || !bus_pwr_ok || rx_lvl;
endmodule

// File: rtl/rs485_ctl_chk.sv
module rs485_ctl_chk #(
  parameter int DIFF_W  = 16,
  parameter int TEMP_W  = 10,
  parameter int SW_MV   = -100,
  parameter int HYST_MV = 7,
  parameter int HOT_C   = 150,
  parameter int COOL_C  = 140
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     drv_en,
  input logic                     rx_en_n,
  input logic                     tx_bit,
  input logic signed [DIFF_W-1:0] diff_mv,
  input logic                     lines_open,
  input logic signed [TEMP_W-1:0] die_temp,
  input logic                     logic_pwr_ok,
  input logic                     bus_pwr_ok,
  input logic                     drv_on,
  input logic                     y_out,
  input logic                     z_out,
  input logic                     rx_out,
  input logic                     rx_hiz,
  input logic                     therm_trip,
  input logic                     rx_lvl
);
  localparam logic signed [DIFF_W-1:0] LO_PT = DIFF_W'(SW_MV - HYST_MV);
  localparam logic signed [DIFF_W-1:0] HI_PT = DIFF_W'(SW_MV + HYST_MV);
  localparam logic signed [TEMP_W-1:0] HOT_T = TEMP_W'(HOT_C);
  localparam logic signed [TEMP_W-1:0] COOL_T = TEMP_W'(COOL_C);

  AST_DRV_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n) drv_on |-> (y_out == tx_bit) && (z_out != y_out)); // R1
  AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n) !drv_en |-> !drv_on && !y_out && !z_out); // R2
  AST_RX_LOW_BAND: assert property (@(posedge clk) disable iff (!rst_n) (!lines_open && diff_mv < LO_PT) |=> !rx_lvl); // R3
  AST_RX_OPEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) lines_open |=> rx_lvl); // R4
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!lines_open && diff_mv >= LO_PT && diff_mv <= HI_PT) |=> rx_lvl == $past(rx_lvl)); // R5
  AST_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) rx_en_n |-> rx_hiz && rx_out); // R6
  AST_HOT_TRIP: assert property (@(posedge clk) disable iff (!rst_n) (die_temp >= HOT_T) |=> therm_trip); // R7
  AST_COOL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (die_temp <= COOL_T) |=> !therm_trip); // R7
  AST_TRIP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) therm_trip |-> !drv_on); // R7
  AST_BUS_DOWN: assert property (@(posedge clk) disable iff (!rst_n) !bus_pwr_ok |-> !drv_on && rx_out); // R8
  AST_LOGIC_DOWN: assert property (@(posedge clk) disable iff (!rst_n) !logic_pwr_ok |-> !drv_on && rx_hiz); // R9
endmodule

bind rs485_ctl rs485_ctl_chk #(
  .DIFF_W(DIFF_W), .TEMP_W(TEMP_W), .SW_MV(SW_MV),
  .HYST_MV(HYST_MV), .HOT_C(HOT_C), .COOL_C(COOL_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .rx_en_n(rx_en_n),
  .tx_bit(tx_bit), .diff_mv(diff_mv), .lines_open(lines_open),
  .die_temp(die_temp), .logic_pwr_ok(logic_pwr_ok), .bus_pwr_ok(bus_pwr_ok),
  .drv_on(drv_on), .y_out(y_out), .z_out(z_out), .rx_out(rx_out),
  .rx_hiz(rx_hiz), .therm_trip(therm_trip), .rx_lvl(rx_lvl)
);

// File: tb/rs485_ctl_tb.sv
module rs485_ctl_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic drv_en = 0, rx_en_n = 1, tx_bit = 0, lines_open = 0;
  logic logic_pwr_ok = 1, bus_pwr_ok = 1;
  logic signed [15:0] diff_mv = 0;
  logic signed [9:0]  die_temp = 25;
  logic drv_on, y_out, z_out, rx_out, rx_hiz, therm_trip;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rs485_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .rx_en_n(rx_en_n),
    .tx_bit(tx_bit), .diff_mv(diff_mv), .lines_open(lines_open),
    .die_temp(die_temp), .logic_pwr_ok(logic_pwr_ok), .bus_pwr_ok(bus_pwr_ok),
    .drv_on(drv_on), .y_out(y_out), .z_out(z_out), .rx_out(rx_out),
    .rx_hiz(rx_hiz), .therm_trip(therm_trip)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic set_diff(input int mv);
    @(negedge clk); diff_mv = 16'(mv); step();
  endtask

  task automatic set_temp(input int t);
    @(negedge clk); die_temp = 10'(t); step();
  endtask

  task automatic t_reset;
    rx_en_n = 0;
    #1;
    chk("R10 trip after reset", therm_trip, 1'b0);
    chk("R10 rx level after reset", rx_out, 1'b1);
  endtask

  task automatic t_driver;
    @(negedge clk); drv_en = 1; tx_bit = 1; #1;
    chk("R1 drv_on", drv_on, 1'b1);
    chk("R1 y=1", y_out, 1'b1);
    chk("R1 z=0", z_out, 1'b0);
    tx_bit = 0; #1;
    chk("R1 y=0", y_out, 1'b0);
    chk("R1 z=1", z_out, 1'b1);
    drv_en = 0; #1;
    chk("R2 drv_on off", drv_on, 1'b0);
    chk("R2 y released", y_out, 1'b0);
    chk("R2 z released", z_out, 1'b0);
  endtask

  task automatic t_thresholds;
    rx_en_n = 0;
    set_diff(-201); chk("R3 below -200", rx_out, 1'b0);
    set_diff(-29);  chk("R3 above -30", rx_out, 1'b1);
    set_diff(-500); chk("R3 strong low", rx_out, 1'b0);
    set_diff(0);    chk("R3 zero diff high", rx_out, 1'b1);
  endtask

  task automatic t_open;
    set_diff(-300);
    @(negedge clk); lines_open = 1; step();
    chk("R4 open forces high", rx_out, 1'b1);
    @(negedge clk); lines_open = 0; step();
    chk("R4 open released", rx_out, 1'b0);
    set_diff(0);
  endtask

  task automatic t_hyst;
    set_diff(-100); chk("R5 hold high at -100", rx_out, 1'b1);
    set_diff(-107); chk("R5 hold high at -107", rx_out, 1'b1);
    set_diff(-108); chk("R5 low below -107", rx_out, 1'b0);
    set_diff(-100); chk("R5 hold low at -100", rx_out, 1'b0);
    set_diff(-93);  chk("R5 hold low at -93", rx_out, 1'b0);
    set_diff(-92);  chk("R5 high above -93", rx_out, 1'b1);
  endtask

  task automatic t_rx_enable;
    set_diff(-300);
    @(negedge clk); rx_en_n = 1; #1;
    chk("R6 hiz", rx_hiz, 1'b1);
    chk("R6 level 1", rx_out, 1'b1);
    rx_en_n = 0; #1;
    chk("R6 enabled", rx_hiz, 1'b0);
    chk("R6 enabled data", rx_out, 1'b0);
  endtask

  task automatic t_thermal;
    @(negedge clk); drv_en = 1;
    set_temp(149); chk("R7 149 no trip", therm_trip, 1'b0);
    set_temp(150); chk("R7 150 trip", therm_trip, 1'b1);
    chk("R7 driver off when tripped", drv_on, 1'b0);
    set_temp(145); chk("R7 hold at 145", therm_trip, 1'b1);
    set_temp(141); chk("R7 hold at 141", therm_trip, 1'b1);
    set_temp(140); chk("R7 clear at 140", therm_trip, 1'b0);
    chk("R7 driver back on", drv_on, 1'b1);
    set_temp(25);
  endtask

  task automatic t_supplies;
    @(negedge clk); bus_pwr_ok = 0; #1;
    chk("R8 driver off bus down", drv_on, 1'b0);
    chk("R8 rx high bus down", rx_out, 1'b1);
    bus_pwr_ok = 1; logic_pwr_ok = 0; #1;
    chk("R9 driver off logic down", drv_on, 1'b0);
    chk("R9 rx released logic down", rx_hiz, 1'b1);
    logic_pwr_ok = 1; #1;
    chk("R9 restored", drv_on, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_driver();
    t_thresholds();
    t_open();
    t_hyst();
    t_rx_enable();
    t_thermal();
    t_supplies();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule